// File: doc/BRIEF.md
# Link-Side Transmit Control Sequencer

This block is the link half of a two-wire-control PHY/link handshake for a serial bus. It sits in the PHY clock domain. After the link has asked for the bus, it watches the PHY's control pair for a grant. Once the grant arrives, it takes over the control pair and the byte lane through output enables. It then walks a fixed choreography of Idle, Hold and Transmit codes, and finally hands both lanes back in high impedance.

One grant can carry a single packet or a chain of packets sent back to back. When no data turns up in time, or the client asks to abandon the bus, the block runs a cancel sequence. With no data sent, the PHY then puts an empty packet on the wire. Speed rules limit which packet speeds may follow one another in a chain. The block reports the speed that applies to the packet in flight.

Top module: `link_tx_seq`

## Requirements
- R1: While reset is high and after it, with no grant seen, both output enables are low, the control output is 00, the byte output is zero and every strobe and flag is low.
- R2: When `phy_ctl_in` is 11 (grant) on a clock edge with `req_pending` high, the block drives exactly one Idle cycle (code 00) starting on the next cycle. It then drives Hold (01) or Transmit (10), unless a cancel is taken.
- R3: The run of Hold cycles is never longer than `max_hold` (a value of 0 acts as 1). If the limit is reached with `pkt_ready` low, the block drives one Idle cycle and releases the lanes, and `hold_timeout` is high for that Idle cycle only. If `pkt_ready` is high in the cycle where the limit is reached, transmission wins and no timeout is raised.
- R4: In every Transmit cycle `ctl_out` is 10, `d_out` equals `tx_data` of that cycle and `byte_take` is high. The cycle in which `tx_last` is high is the last byte of the packet.
- R5: After the last byte, when `more_pkt` is low, the block drives Idle for two cycles and then drops both enables.
- R6: A `cancel_req` during the post-grant Idle cycle wins over `pkt_ready`. It adds one further Idle cycle (two in total) before release.
- R7: A `cancel_req` during a Hold cycle gives one Idle cycle, then release.
- R8: When `tx_last` and `more_pkt` are both high, the next cycle is Hold, and the next packet is awaited under a fresh Hold limit.
- R9: With `multi_en` high, a packet that follows an S100 packet (speed code 00) in the same chain at any other code is refused. The block drives one Idle cycle with `speed_reject` high, then releases the lanes. A change from a faster code to S100 is accepted.
- R10: With `multi_en` low, `cur_speed` during every packet of a chain equals the `tx_speed` given for the first packet, whatever later packets request.
- R11: A grant code seen while `req_pending` is low is ignored. Outside driving states the enables are low and `byte_take` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pending | input | 1 | A bus request has been issued and is outstanding |
| phy_ctl_in | input | 2 | Control pair as driven by the PHY (00 idle, 11 grant) |
| pkt_ready | input | 1 | The next packet is ready to be sent |
| cancel_req | input | 1 | Abandon the bus instead of sending |
| tx_data | input | DW | Byte presented for the current Transmit cycle |
| tx_last | input | 1 | Current byte is the last of the packet |
| more_pkt | input | 1 | Another packet follows in the same chain (sampled with `tx_last`) |
| tx_speed | input | 2 | Requested speed code of the packet (00 S100, 01 S200, 10 S400) |
| multi_en | input | 1 | Allow differing speeds within a chain |
| max_hold | input | HOLD_W | Longest allowed run of Hold cycles |
| ctl_out | output | 2 | Control pair driven by the link (00 idle, 01 hold, 10 transmit) |
| ctl_oe | output | 1 | Output enable of the control pair |
| d_out | output | DW | Byte lane driven by the link |
| d_oe | output | 1 | Output enable of the byte lane |
| byte_take | output | 1 | `tx_data` is consumed in this cycle |
| cur_speed | output | 2 | Speed code in force for the packet being sent |
| hold_timeout | output | 1 | One-cycle flag: the Hold limit ended the connection |
| speed_reject | output | 1 | One-cycle flag: a chained packet broke the speed rule |

## Verification
Two decisions can fall in the same Hold cycle. The Hold limit can expire in the very cycle that `pkt_ready` rises, and a ready packet can meet the speed rule that refuses it. The bench sets `max_hold` so that readiness arrives exactly on the final permitted Hold cycle. It then expects Transmit on the next cycle with `hold_timeout` staying low. In a chain, it raises readiness for an S400 packet after an S100 one and expects a one-cycle Idle with `speed_reject` instead of Transmit. It also sets `cancel_req` together with `pkt_ready` in the post-grant Idle cycle, where the cancel has to win.

// File: rtl/lts_pkg.sv
package lts_pkg;

    // Codes the link places on the control pair
    localparam logic [1:0] LNK_IDLE  = 2'b00;
    localparam logic [1:0] LNK_HOLD  = 2'b01;
    localparam logic [1:0] LNK_XMIT  = 2'b10;

    // Code the PHY places on the control pair to hand over the bus
    localparam logic [1:0] PHY_GRANT = 2'b11;

    // Slowest speed code
    localparam logic [1:0] SPD_S100  = 2'b00;

    typedef enum logic [2:0] {
        ST_WAIT,      // lanes released, watching for a grant
        ST_GNT_IDLE,  // single Idle after the grant
        ST_HOLD,      // keeping the bus while data is not ready
        ST_XMIT,      // sending bytes
        ST_END1,      // first Idle after a packet
        ST_END2,      // second Idle after a packet or a grant cancel
        ST_DROP       // single Idle that ends a Hold
    } seq_state_e;

    // Why a Hold was left through ST_DROP
    typedef struct packed {
        logic timeout;
        logic reject;
    } drop_cause_t;

    // A chained packet faster than S100 may not follow an S100 packet
    function automatic logic spd_forbidden(input logic [1:0] prev, input logic [1:0] nxt);
        return (prev == SPD_S100) && (nxt != SPD_S100);
    endfunction

    function automatic logic drives_bus(input seq_state_e s);
        return s != ST_WAIT;
    endfunction

    function automatic logic [1:0] ctl_code(input seq_state_e s);
        logic [1:0] c;
        case (s)
            ST_HOLD: c = LNK_HOLD;
            ST_XMIT: c = LNK_XMIT;
            default: c = LNK_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lts_hold_timer.sv
module lts_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [HOLD_W-1:0] max_hold,
    output logic              expired
);
    localparam logic [HOLD_W-1:0] ONE  = HOLD_W'(1);
    localparam logic [HOLD_W-1:0] FULL = {HOLD_W{1'b1}};

    // Counts the Hold cycles spent so far, including the current one
    logic [HOLD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ONE;
        end else if (run && cnt != FULL) begin
            cnt <= cnt + ONE;
        end
    end

    // A limit of zero already counts as reached on the first Hold cycle
    assign expired = (cnt >= max_hold);

    // R3: a Hold run never counts past the programmed limit
    a_r3_hold_bound: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(max_hold) && max_hold != '0) |-> (cnt <= max_hold));

endmodule

// File: rtl/lts_speed_guard.sv
module lts_speed_guard
    import lts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       run_end,
    input  logic       multi_en,
    input  logic [1:0] req_speed,
    output logic       reject,
    output logic [1:0] cur_speed
);
    logic       first_q;
    logic [1:0] first_spd;
    logic [1:0] prev_spd;
    logic [1:0] eff_spd;

    // Without multi-speed, later packets inherit the speed of the first one
    assign eff_spd = (!multi_en && !first_q) ? first_spd : req_speed;

    // Only chained packets are checked; the first packet of a grant is free
    assign reject = !first_q && multi_en && spd_forbidden(prev_spd, req_speed);

    always_ff @(posedge clk) begin
        if (rst || run_end) begin
            first_q <= 1'b1;
            if (rst) begin
                first_spd <= SPD_S100;
                prev_spd  <= SPD_S100;
                cur_speed <= SPD_S100;
            end
        end else if (start) begin
            first_q   <= 1'b0;
            prev_spd  <= eff_spd;
            cur_speed <= eff_spd;
            if (first_q) begin
                first_spd <= req_speed;
            end
        end
    end

    // R10: with multi-speed off, a chained packet runs at the first packet's speed
    a_r10_first_speed: assert property (@(posedge clk) disable iff (rst)
        (start && !run_end && !multi_en && !first_q) |=> (cur_speed == $past(first_spd)));

endmodule

// File: rtl/lts_fsm.sv
module lts_fsm
    import lts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_pending,
    input  logic [1:0] phy_ctl_in,
    input  logic       pkt_ready,
    input  logic       cancel_req,
    input  logic       tx_last,
    input  logic       more_pkt,
    input  logic       hold_expired,
    input  logic       speed_bad,
    output seq_state_e state,
    output logic       hold_load,
    output logic       hold_run,
    output logic       xmit_start,
    output logic       run_end,
    output logic       timeout_flag,
    output logic       reject_flag
);
    seq_state_e  nxt;
    drop_cause_t cause_n;
    drop_cause_t cause_q;

    always_comb begin
        nxt     = state;
        cause_n = '0;
        case (state)
            ST_WAIT: begin
                if (req_pending && phy_ctl_in == PHY_GRANT) nxt = ST_GNT_IDLE;
            end
            ST_GNT_IDLE: begin
                if (cancel_req)     nxt = ST_END2;
                else if (pkt_ready) nxt = ST_XMIT;
                else                nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cancel_req) begin
                    nxt = ST_DROP;
                end else if (pkt_ready) begin
                    if (speed_bad) begin
                        nxt            = ST_DROP;
                        cause_n.reject = 1'b1;
                    end else begin
                        nxt = ST_XMIT;
                    end
                end else if (hold_expired) begin
                    nxt             = ST_DROP;
                    cause_n.timeout = 1'b1;
                end
            end
            ST_XMIT: begin
                if (tx_last) nxt = more_pkt ? ST_HOLD : ST_END1;
            end
            ST_END1: nxt = ST_END2;
            ST_END2: nxt = ST_WAIT;
            ST_DROP: nxt = ST_WAIT;
            default: nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT;
            cause_q <= '0;
        end else begin
            state   <= nxt;
            cause_q <= cause_n;
        end
    end

    assign hold_load    = (nxt == ST_HOLD) && (state != ST_HOLD);
    assign hold_run     = (state == ST_HOLD);
    assign xmit_start   = (nxt == ST_XMIT) && (state != ST_XMIT);
    assign run_end      = (state == ST_WAIT);
    assign timeout_flag = cause_q.timeout;
    assign reject_flag  = cause_q.reject;

    // R7: a cancel seen in Hold leaves Hold at the next edge
    a_r7_cancel_leaves_hold: assert property (@(posedge clk) disable iff (rst)
        (hold_run && cancel_req) |=> (state == ST_DROP && !timeout_flag && !reject_flag));

endmodule

// File: rtl/link_tx_seq.sv
module link_tx_seq
    import lts_pkg::*;
#(
    parameter int DW     = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_pending,
    input  logic [1:0]        phy_ctl_in,
    input  logic              pkt_ready,
    input  logic              cancel_req,
    input  logic [DW-1:0]     tx_data,
    input  logic              tx_last,
    input  logic              more_pkt,
    input  logic [1:0]        tx_speed,
    input  logic              multi_en,
    input  logic [HOLD_W-1:0] max_hold,
    output logic [1:0]        ctl_out,
    output logic              ctl_oe,
    output logic [DW-1:0]     d_out,
    output logic              d_oe,
    output logic              byte_take,
    output logic [1:0]        cur_speed,
    output logic              hold_timeout,
    output logic              speed_reject
);
    seq_state_e state;
    logic       hold_load;
    logic       hold_run;
    logic       hold_expired;
    logic       xmit_start;
    logic       run_end;
    logic       speed_bad;

    lts_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_pending  (req_pending),
        .phy_ctl_in   (phy_ctl_in),
        .pkt_ready    (pkt_ready),
        .cancel_req   (cancel_req),
        .tx_last      (tx_last),
        .more_pkt     (more_pkt),
        .hold_expired (hold_expired),
        .speed_bad    (speed_bad),
        .state        (state),
        .hold_load    (hold_load),
        .hold_run     (hold_run),
        .xmit_start   (xmit_start),
        .run_end      (run_end),
        .timeout_flag (hold_timeout),
        .reject_flag  (speed_reject)
    );

    lts_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (hold_load),
        .run      (hold_run),
        .max_hold (max_hold),
        .expired  (hold_expired)
    );

    lts_speed_guard u_speed (
        .clk       (clk),
        .rst       (rst),
        .start     (xmit_start),
        .run_end   (run_end),
        .multi_en  (multi_en),
        .req_speed (tx_speed),
        .reject    (speed_bad),
        .cur_speed (cur_speed)
    );

    assign ctl_oe    = drives_bus(state);
    assign d_oe      = drives_bus(state);
    assign ctl_out   = ctl_code(state);
    assign byte_take = (state == ST_XMIT);
    assign d_out     = (state == ST_XMIT) ? tx_data : '0;

    // R2: the first driven cycle follows a qualified grant and is Idle
    a_r2_grant_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_oe) |-> (ctl_out == LNK_IDLE && $past(phy_ctl_in) == PHY_GRANT && $past(req_pending)));

    // R5: the lanes are only released after an Idle cycle
    a_r5_release_after_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_oe) |-> ($past(ctl_out) == LNK_IDLE));

    // R3: a timeout shows in a single Idle cycle that directly follows Hold
    a_r3_timeout_single: assert property (@(posedge clk) disable iff (rst)
        hold_timeout |-> (ctl_oe && ctl_out == LNK_IDLE && $past(ctl_out) == LNK_HOLD));

    a_r3_timeout_release: assert property (@(posedge clk) disable iff (rst)
        hold_timeout |=> (!ctl_oe && !hold_timeout));

    // R9: a refused chained packet gives one Idle, then release
    a_r9_reject_release: assert property (@(posedge clk) disable iff (rst)
        speed_reject |=> (!ctl_oe && !speed_reject));

    // R11: nothing is driven or consumed with the enables low
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctl_oe |-> (ctl_out == LNK_IDLE && d_out == '0 && !byte_take && !d_oe));

endmodule

// File: tb/test_link_tx_seq.sv
`timescale 1ns/1ps
module test_link_tx_seq;

    localparam logic [1:0] IDL = 2'b00;
    localparam logic [1:0] HLD = 2'b01;
    localparam logic [1:0] TXC = 2'b10;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_pending;
    logic [1:0] phy_ctl_in;
    logic       pkt_ready;
    logic       cancel_req;
    logic [7:0] tx_data;
    logic       tx_last;
    logic       more_pkt;
    logic [1:0] tx_speed;
    logic       multi_en;
    logic [7:0] max_hold;
    logic [1:0] ctl_out;
    logic       ctl_oe;
    logic [7:0] d_out;
    logic       d_oe;
    logic       byte_take;
    logic [1:0] cur_speed;
    logic       hold_timeout;
    logic       speed_reject;

    always #2 clk = ~clk;

    link_tx_seq i_link_tx_seq (
        .clk(clk), .rst(rst), .req_pending(req_pending), .phy_ctl_in(phy_ctl_in),
        .pkt_ready(pkt_ready), .cancel_req(cancel_req), .tx_data(tx_data),
        .tx_last(tx_last), .more_pkt(more_pkt), .tx_speed(tx_speed),
        .multi_en(multi_en), .max_hold(max_hold), .ctl_out(ctl_out),
        .ctl_oe(ctl_oe), .d_out(d_out), .d_oe(d_oe), .byte_take(byte_take),
        .cur_speed(cur_speed), .hold_timeout(hold_timeout), .speed_reject(speed_reject)
    );

    typedef struct {
        string      tag;
        logic       oe;
        logic [1:0] ctl;
        logic [7:0] d;
        logic       to;
        logic       rj;
        logic       chk_spd;
        logic [1:0] spd;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Staged stimulus, applied at the falling edge by cyc()
    logic       s_rst = 1'b1, s_req = 1'b0, s_ready = 1'b0, s_cancel = 1'b0;
    logic       s_last = 1'b0, s_more = 1'b0, s_multi = 1'b1;
    logic [1:0] s_phy = 2'b00, s_spd = 2'b00;
    logic [7:0] s_data = 8'h00, s_max = 8'd4;

    initial begin
        rst = 1'b1; req_pending = 1'b0; phy_ctl_in = 2'b00; pkt_ready = 1'b0;
        cancel_req = 1'b0; tx_data = 8'h00; tx_last = 1'b0; more_pkt = 1'b0;
        tx_speed = 2'b00; multi_en = 1'b1; max_hold = 8'd4;
    end

    task automatic cyc(input string tag, input logic oe, input logic [1:0] ctl,
                       input logic [7:0] d, input logic to, input logic rj,
                       input logic chk, input logic [1:0] spd);
        exp_t e;
        @(negedge clk);
        rst = s_rst; req_pending = s_req; phy_ctl_in = s_phy; pkt_ready = s_ready;
        cancel_req = s_cancel; tx_data = s_data; tx_last = s_last; more_pkt = s_more;
        tx_speed = s_spd; multi_en = s_multi; max_hold = s_max;
        e.tag = tag; e.oe = oe; e.ctl = ctl; e.d = d; e.to = to; e.rj = rj;
        e.chk_spd = chk; e.spd = spd;
        sb.push_back(e);
    endtask

    task automatic quiet_stage();
        s_req = 1'b0; s_phy = 2'b00; s_ready = 1'b0; s_cancel = 1'b0;
        s_last = 1'b0; s_more = 1'b0;
    endtask

    // Monitor: one expectation per cycle, sampled late in the cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                logic take_exp;
                e = sb.pop_front();
                take_exp = e.oe && (e.ctl == TXC);
                n_checks++;
                if (ctl_oe !== e.oe || d_oe !== e.oe || ctl_out !== e.ctl ||
                    d_out !== e.d || byte_take !== take_exp ||
                    hold_timeout !== e.to || speed_reject !== e.rj ||
                    (e.chk_spd && cur_speed !== e.spd)) begin
                    n_fail++;
                    $display("FAIL %s: oe=%b/%b ctl=%b d=%h take=%b to=%b rj=%b spd=%b expected oe=%b ctl=%b d=%h take=%b to=%b rj=%b spd=%b",
                             e.tag, ctl_oe, d_oe, ctl_out, d_out, byte_take, hold_timeout,
                             speed_reject, cur_speed, e.oe, e.ctl, e.d, take_exp, e.to,
                             e.rj, e.spd);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc("R1", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R1", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_rst = 1'b0;
        cyc("R1", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R11: grant without a pending request is ignored
        quiet_stage(); s_phy = 2'b11;
        cyc("R11", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_phy = 2'b00;
        cyc("R11", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R2, R4, R5: single packet
        s_req = 1'b1; s_phy = 2'b11;
        cyc("R2", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00; s_ready = 1'b1; s_data = 8'hA1; s_spd = 2'b01;
        cyc("R2", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0; s_data = 8'hA2;
        cyc("R4", 1, TXC, 8'hA2, 0, 0, 1, 2'b01);
        s_data = 8'hA3; s_last = 1'b1;
        cyc("R4", 1, TXC, 8'hA3, 0, 0, 1, 2'b01);
        s_last = 1'b0; s_data = 8'h00;
        cyc("R5", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R5", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R5", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R3: Hold limit of 3 expires
        quiet_stage(); s_max = 8'd3; s_req = 1'b1; s_phy = 2'b11;
        cyc("R3", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00;
        cyc("R3", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R3", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        cyc("R3", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        cyc("R3", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        cyc("R3", 1, IDL, 8'h00, 1, 0, 0, 2'b00);
        cyc("R3", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R3: readiness on the last allowed Hold cycle wins over the timeout
        quiet_stage(); s_max = 8'd2; s_req = 1'b1; s_phy = 2'b11;
        cyc("R3", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00;
        cyc("R3", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R3", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b1; s_spd = 2'b10;
        cyc("R3", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0; s_data = 8'hB1; s_last = 1'b1;
        cyc("R3", 1, TXC, 8'hB1, 0, 0, 1, 2'b10);
        s_last = 1'b0; s_data = 8'h00;
        cyc("R5", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R5", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R5", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R6: cancel in the post-grant Idle beats a ready packet
        quiet_stage(); s_max = 8'd8; s_req = 1'b1; s_phy = 2'b11;
        cyc("R6", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00; s_cancel = 1'b1; s_ready = 1'b1;
        cyc("R6", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_cancel = 1'b0; s_ready = 1'b0;
        cyc("R6", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R6", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R7: cancel from Hold
        quiet_stage(); s_req = 1'b1; s_phy = 2'b11;
        cyc("R7", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00;
        cyc("R7", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_cancel = 1'b1;
        cyc("R7", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_cancel = 1'b0;
        cyc("R7", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R7", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R8, R9: chain S200 -> S100 accepted, S100 -> S400 refused
        quiet_stage(); s_multi = 1'b1; s_req = 1'b1; s_phy = 2'b11;
        cyc("R8", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00; s_ready = 1'b1; s_spd = 2'b01;
        cyc("R8", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0; s_data = 8'hC1; s_last = 1'b1; s_more = 1'b1;
        cyc("R8", 1, TXC, 8'hC1, 0, 0, 1, 2'b01);
        s_last = 1'b0; s_more = 1'b0; s_data = 8'h00;
        cyc("R8", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b1; s_spd = 2'b00;
        cyc("R8", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0; s_data = 8'hC2; s_last = 1'b1; s_more = 1'b1;
        cyc("R9", 1, TXC, 8'hC2, 0, 0, 1, 2'b00);
        s_last = 1'b0; s_more = 1'b0; s_data = 8'h00; s_ready = 1'b1; s_spd = 2'b10;
        cyc("R9", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0;
        cyc("R9", 1, IDL, 8'h00, 0, 1, 0, 2'b00);
        cyc("R9", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        // R10: multi-speed off, second packet keeps the first speed
        quiet_stage(); s_multi = 1'b0; s_req = 1'b1; s_phy = 2'b11;
        cyc("R10", 0, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_req = 1'b0; s_phy = 2'b00; s_ready = 1'b1; s_spd = 2'b10;
        cyc("R10", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0; s_data = 8'hD1; s_last = 1'b1; s_more = 1'b1;
        cyc("R10", 1, TXC, 8'hD1, 0, 0, 1, 2'b10);
        s_last = 1'b0; s_more = 1'b0; s_data = 8'h00; s_ready = 1'b1; s_spd = 2'b00;
        cyc("R10", 1, HLD, 8'h00, 0, 0, 0, 2'b00);
        s_ready = 1'b0; s_data = 8'hD2; s_last = 1'b1;
        cyc("R10", 1, TXC, 8'hD2, 0, 0, 1, 2'b10);
        s_last = 1'b0; s_data = 8'h00;
        cyc("R10", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R10", 1, IDL, 8'h00, 0, 0, 0, 2'b00);
        cyc("R10", 0, IDL, 8'h00, 0, 0, 0, 2'b00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule